// File: doc/BRIEF.md
# Synchronous clock stop controller

The block produces a group of divided output clocks from a fast reference clock. Each output can be stopped on request and held at logic low while the divider and any free-running outputs keep toggling. The run condition is the AND of two sources: an asynchronous active-low stop pin, and a run bit in a small register. If either one is low, every stoppable output halts. The pin passes through a two-flop synchronizer before it is combined with the register bit. The status output shows the combined condition, so it reads 0 whenever the stoppable clocks are not running.

Each output has a free-run mask bit and an enable input. An output whose mask bit is set ignores the stop request. An output whose enable is low is held low. The gate of each output changes only at the falling edge of the divided clock, after a complete high phase. Because of this, stopping, restarting and enabling never produce a shortened pulse. When the request is released, all stoppable outputs resume on the same reference cycle, within two output periods. The divide ratio must be even and at least 4.

Top module: `clk_stop_ctrl`

## Requirements
- R1: During reset every output clock is 0 and `run_status` is 1. After reset the register run bit is 1 and the free-run mask is 0, so every output is stoppable.
- R2: When `stop_pin_n` is held low, every output whose mask bit is 0 stays at 0.
- R3: When the register run bit is written 0 with `reg_we`, every output whose mask bit is 0 stays at 0, even if the pin is high.
- R4: `run_status` equals the synchronized pin AND the register run bit. It goes to 0 two reference cycles after the pin is sampled low, and one cycle after a write of run bit 0.
- R5: An output whose mask bit is 1 and whose enable is 1 keeps running whatever the stop pin and the run bit are.
- R6: An output whose `out_en` bit is 0 stays at 0.
- R7: Every high pulse on an output lasts exactly DIV/2 reference cycles, and every low interval lasts at least DIV/2 cycles. This holds on stop, on restart, on enable changes and on mask changes.
- R8: After the pin is released (with the run bit at 1), each enabled stoppable output rises within 2*DIV reference cycles.
- R9: The stoppable outputs that resume together rise on the same reference cycle.
- R10: A running output has a period of DIV reference cycles, high for DIV/2 of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_pin_n | input | 1 | Asynchronous stop request, active low |
| reg_we | input | 1 | Write strobe for the run bit and the mask |
| reg_run_wr | input | 1 | Run bit value to write (0 requests a stop) |
| reg_mask_wr | input | N | Free-run mask to write, one bit per output |
| out_en | input | N | Per-output enable |
| gclk | output | N | Gated divided output clocks |
| run_status | output | 1 | Combined run condition read-back |

## Verification
Two functions can fall in the same reference cycle: release of the pin and a register write, and a stop request and a mask write. The bench forces each collision on purpose. In one case it raises the pin on the same edge that writes run bit 0, and expects the outputs to stay stopped with the status low. In the other case it lowers the pin on the same edge that frees output 0, and expects output 0 to keep toggling while the others halt. Pulse-width monitoring runs through both collisions and catches any runt pulse.

// File: rtl/ckstop_pkg.sv
package ckstop_pkg;
    typedef enum logic {
        GATE_HOLD = 1'b0,
        GATE_PASS = 1'b1
    } gate_e;
endpackage

// File: rtl/ckstop_sync.sv
module ckstop_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic [1:0] stg;
    } sync_s;

    sync_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stg = {st_q.stg[0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{stg: {2{RST_VAL}}};
        else        st_q <= st_d;
    end

    assign q = st_q.stg[1];
endmodule

// File: rtl/ckstop_div.sv
module ckstop_div #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic base_nx,
    output logic at_fall
);
    localparam int unsigned CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST_C  = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF_C  = CW'(DIV / 2);
    localparam logic [CW-1:0] PRE_C   = CW'(DIV / 2 - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_s;

    div_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST_C) st_d.cnt = '0;
        else                    st_d.cnt = st_q.cnt + CW'(1);
        base_nx = (st_d.cnt < HALF_C);
        at_fall = (st_q.cnt == PRE_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ckstop_gate.sv
module ckstop_gate
    import ckstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic at_fall,
    input  logic base_nx,
    output logic gclk
);
    typedef struct packed {
        gate_e gate;
        logic  out;
    } gate_s;

    gate_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (at_fall) st_d.gate = want ? GATE_PASS : GATE_HOLD;
        st_d.out = base_nx && (st_d.gate == GATE_PASS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{gate: GATE_HOLD, out: 1'b0};
        else        st_q <= st_d;
    end

    assign gclk = st_q.out;
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
    parameter int unsigned N   = 3,
    parameter int unsigned DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stop_pin_n,
    input  logic         reg_we,
    input  logic         reg_run_wr,
    input  logic [N-1:0] reg_mask_wr,
    input  logic [N-1:0] out_en,
    output logic [N-1:0] gclk,
    output logic         run_status
);
    typedef struct packed {
        logic         run;
        logic [N-1:0] mask;
    } ctl_s;

    ctl_s         ctl_d, ctl_q;
    logic         pin_s;
    logic         base_nx;
    logic         at_fall;
    logic [N-1:0] want;
    logic [N-1:0] mask_cur;

    always_comb begin
        ctl_d = ctl_q;
        if (reg_we) begin
            ctl_d.run  = reg_run_wr;
            ctl_d.mask = reg_mask_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{run: 1'b1, mask: '0};
        else        ctl_q <= ctl_d;
    end

    ckstop_sync #(.RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stop_pin_n),
        .q     (pin_s)
    );

    ckstop_div #(.DIV(DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_nx (base_nx),
        .at_fall (at_fall)
    );

    assign run_status = pin_s & ctl_q.run;
    assign mask_cur   = ctl_q.mask;

    for (genvar i = 0; i < N; i++) begin : g_out
        assign want[i] = out_en[i] & (ctl_q.mask[i] | run_status);
        ckstop_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .want    (want[i]),
            .at_fall (at_fall),
            .base_nx (base_nx),
            .gclk    (gclk[i])
        );
    end
endmodule

// File: rtl/ckstop_chk.sv
module ckstop_chk #(
    parameter int unsigned N   = 3,
    parameter int unsigned DIV = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         stop_pin_n,
    input logic         reg_we,
    input logic         reg_run_wr,
    input logic [N-1:0] out_en,
    input logic [N-1:0] mask_cur,
    input logic [N-1:0] gclk,
    input logic         run_status
);
    localparam int unsigned SAT = 3 * DIV;
    localparam int unsigned CW  = $clog2(SAT + 1) + 1;
    localparam logic [CW-1:0] SAT_C  = CW'(SAT);
    localparam logic [CW-1:0] HALF_C = CW'(DIV / 2);
    localparam logic [CW-1:0] STOP_C = CW'(DIV + 1);
    localparam logic [CW-1:0] RES_C  = CW'(2 * DIV);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            a_reset_low_r1: assert (gclk == '0);
        end
    end

    // R4: pin sampled low two edges ago forces status low
    p_status_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && !$past(stop_pin_n, 2)) |-> !run_status);

    p_status_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_we) && !$past(reg_run_wr)) |-> !run_status);

    for (genvar i = 0; i < N; i++) begin : g_chk
        logic [CW-1:0] hi_cnt, lo_cnt, want_cnt, stop_cnt;
        logic          want_i;

        assign want_i = out_en[i] & (mask_cur[i] | run_status);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_cnt   <= '0;
                lo_cnt   <= '0;
                want_cnt <= '0;
                stop_cnt <= '0;
            end else begin
                hi_cnt   <= gclk[i] ? ((hi_cnt == SAT_C) ? hi_cnt : hi_cnt + CW'(1)) : '0;
                lo_cnt   <= !gclk[i] ? ((lo_cnt == SAT_C) ? lo_cnt : lo_cnt + CW'(1)) : '0;
                want_cnt <= want_i ? ((want_cnt == SAT_C) ? want_cnt : want_cnt + CW'(1)) : '0;
                stop_cnt <= !want_i ? ((stop_cnt == SAT_C) ? stop_cnt : stop_cnt + CW'(1)) : '0;
            end
        end

        p_high_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gclk[i]) |-> (hi_cnt == HALF_C));

        p_low_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gclk[i]) |-> (lo_cnt >= HALF_C));

        // R2, R3, R6: a held stop keeps the output low
        p_stopped_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_cnt > STOP_C) |-> !gclk[i]);

        // R8, R5: a wanted output is toggling after 2*DIV cycles
        p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (want_cnt > RES_C) |-> (lo_cnt <= HALF_C));
    end
endmodule

bind clk_stop_ctrl ckstop_chk #(.N(N), .DIV(DIV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_pin_n (stop_pin_n),
    .reg_we     (reg_we),
    .reg_run_wr (reg_run_wr),
    .out_en     (out_en),
    .mask_cur   (mask_cur),
    .gclk       (gclk),
    .run_status (run_status)
);

// File: tb/sim_clk_stop_ctrl.sv
module sim_clk_stop_ctrl;
    localparam int N    = 3;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic         stop_pin_n = 1'b1;
    logic         reg_we = 1'b0;
    logic         reg_run_wr = 1'b1;
    logic [N-1:0] reg_mask_wr = '0;
    logic [N-1:0] out_en = '0;
    logic [N-1:0] gclk;
    logic         run_status;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 0;
    bit done = 0;
    int hl [N];
    int ll [N];
    bit prv [N];

    always #2 clk = ~clk;

    clk_stop_ctrl #(.N(N), .DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_pin_n(stop_pin_n), .reg_we(reg_we),
        .reg_run_wr(reg_run_wr), .reg_mask_wr(reg_mask_wr), .out_en(out_en),
        .gclk(gclk), .run_status(run_status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3 * DIV + 4) @(negedge clk);
    endtask

    task automatic count_highs(output int cnt [N]);
        for (int i = 0; i < N; i++) cnt[i] = 0;
        for (int k = 0; k < 2 * DIV; k++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) if (gclk[i]) cnt[i]++;
        end
    endtask

    // R7: pulse widths monitored at every negedge
    always @(negedge clk) begin
        if (mon_on) begin
            for (int i = 0; i < N; i++) begin
                if (prv[i] && !gclk[i]) begin
                    check(hl[i] == HALF, "R7 high pulse width", hl[i], HALF);
                    ll[i] = 0;
                end else if (!prv[i] && gclk[i]) begin
                    check(ll[i] >= HALF, "R7 low gap width", ll[i], HALF);
                    hl[i] = 0;
                end
                if (gclk[i]) hl[i]++; else ll[i]++;
                prv[i] = gclk[i];
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt [N];
        int n;
        #1 rst_n = 1'b0;
        out_en = '1;
        repeat (3) @(negedge clk);
        check(gclk == '0, "R1 outputs low in reset", int'(gclk), 0);
        check(run_status == 1'b1, "R1 status in reset", int'(run_status), 1);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin hl[i] = 0; ll[i] = HALF; prv[i] = 0; end
        mon_on = 1;
        settle();
        count_highs(cnt);
        check(cnt[0] == DIV && cnt[2] == DIV, "R10 running after reset", cnt[0], DIV);
        // R1: default mask 0 means pin stop halts every output
        stop_pin_n = 1'b0;
        settle();
        count_highs(cnt);
        check(cnt[0] + cnt[1] + cnt[2] == 0, "R1 default mask stoppable",
              cnt[0] + cnt[1] + cnt[2], 0);
        check(run_status == 1'b0, "R4 status with pin low", int'(run_status), 0);

        // sweep pin, run bit, mask and enables
        for (int p = 0; p < 2; p++)
            for (int r = 0; r < 2; r++)
                for (int m = 0; m < 8; m++)
                    for (int e = 0; e < 8; e++) begin
                        bit run;
                        @(negedge clk);
                        stop_pin_n = p[0];
                        out_en = e[N-1:0];
                        reg_we = 1'b1;
                        reg_run_wr = r[0];
                        reg_mask_wr = m[N-1:0];
                        @(negedge clk);
                        reg_we = 1'b0;
                        settle();
                        run = p[0] & r[0];
                        check(run_status == run, "R4 status AND", int'(run_status), int'(run));
                        count_highs(cnt);
                        for (int i = 0; i < N; i++) begin
                            bit w;
                            int ex;
                            w = e[i] & (m[i] | run);
                            ex = w ? DIV : 0;
                            if (!e[i])     check(cnt[i] == ex, "R6 disabled output", cnt[i], ex);
                            else if (m[i]) check(cnt[i] == ex, "R5 free-run output", cnt[i], ex);
                            else if (run)  check(cnt[i] == ex, "R10 running output", cnt[i], ex);
                            else if (!p[0]) check(cnt[i] == ex, "R2 pin stop", cnt[i], ex);
                            else           check(cnt[i] == ex, "R3 register stop", cnt[i], ex);
                        end
                    end

        // R8, R9: release latency over every divider phase
        for (int k = 0; k < DIV; k++) begin
            @(negedge clk);
            out_en = '1;
            reg_we = 1'b1; reg_run_wr = 1'b1; reg_mask_wr = '0;
            stop_pin_n = 1'b0;
            @(negedge clk);
            reg_we = 1'b0;
            repeat (3 * DIV + k) @(negedge clk);
            stop_pin_n = 1'b1;
            n = 0;
            while (gclk == '0 && n <= 3 * DIV) begin
                @(negedge clk);
                n++;
            end
            check(n <= 2 * DIV, "R8 resume latency", n, 2 * DIV);
            check(gclk == '1, "R9 outputs resume together", int'(gclk), 7);
        end

        // collision: pin release and run-bit clear on one edge
        @(negedge clk);
        stop_pin_n = 1'b0;
        settle();
        stop_pin_n = 1'b1;
        reg_we = 1'b1; reg_run_wr = 1'b0; reg_mask_wr = '0;
        @(negedge clk);
        reg_we = 1'b0;
        settle();
        check(run_status == 1'b0, "R3 status after collision", int'(run_status), 0);
        count_highs(cnt);
        check(cnt[0] + cnt[1] + cnt[2] == 0, "R3 stays stopped in collision",
              cnt[0] + cnt[1] + cnt[2], 0);

        // collision: stop request and mask write on one edge
        @(negedge clk);
        reg_we = 1'b1; reg_run_wr = 1'b1; reg_mask_wr = '0;
        @(negedge clk);
        reg_we = 1'b0;
        settle();
        stop_pin_n = 1'b0;
        reg_we = 1'b1; reg_run_wr = 1'b1; reg_mask_wr = 3'b001;
        @(negedge clk);
        reg_we = 1'b0;
        settle();
        count_highs(cnt);
        check(cnt[0] == DIV, "R5 freed output keeps running", cnt[0], DIV);
        check(cnt[1] == 0 && cnt[2] == 0, "R2 others stop", cnt[1] + cnt[2], 0);

        done = 1;
        mon_on = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule